// File: doc/BRIEF.md
# Leaky Integrate-and-Fire Neuron

This block is a single clocked spiking neuron. It keeps a membrane potential in a register. Each clock edge changes the potential in one of two ways, chosen by a phase control. In the integrate phase, the synaptic input value is added to the potential. In the leak phase, a programmable leak amount is subtracted from it. A single adder does both jobs. For the leak, it adds the bitwise complement of the leak amount and forces the carry-in to one.

A comparator checks the freshly computed potential against a firing level that is set for each instance. It examines the most significant bit first. When the potential has reached the firing level, the neuron emits a spike for one clock. On that same edge, a multiplexer on the feedback path loads zero in place of the adder result. The potential never wraps: a sum above the maximum saturates at the maximum, and a leak that would go below zero stops at zero.

Top module: `lif_neuron_core`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the next state is `potential` = 0 and `spike` = 0.
- R2: With `leak_phase` = 0 and no fire, the potential after the edge equals the previous potential plus `syn_in`.
- R3: If the integrate sum exceeds 255, the value used is 255 and never the wrapped sum. Because 255 is at or above any firing level, such an edge always fires.
- R4: With `leak_phase` = 1 and no fire, the potential after the edge equals the previous potential minus `leak_amt`. A leak held high for N edges subtracts N times. The effect becomes visible one edge after the control is raised.
- R5: A leak larger than the current potential leaves zero, never a wrapped value.
- R6: `spike` is high for exactly the edges whose newly computed value (after saturation or clamping) is greater than or equal to `fire_level`. It is a registered output. With `syn_in` = 1, `fire_level` = 32 and no leak, `spike` rises on the 32nd edge after reset.
- R7: On every edge that fires, `potential` loads 0. Integration then restarts from zero.
- R8: The firing decision is correct for every 8-bit firing level. The comparator resolves at the highest bit where the two values differ.
- R9: With `fire_level` = 0, every edge fires, and `potential` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| syn_in | input | 8 | Value added to the potential in the integrate phase |
| leak_phase | input | 1 | 0 = integrate, 1 = leak |
| leak_amt | input | 8 | Amount subtracted per edge in the leak phase |
| fire_level | input | 8 | Firing threshold of this neuron (unsigned) |
| spike | output | 1 | One-clock fire pulse, registered |
| potential | output | 8 | Current membrane potential, registered |

## Verification
Both outputs come from a single register stage. Inputs applied before rising edge k therefore show up in `potential` and `spike` after edge k, with no extra latency in the leak or fire paths. The bench drives inputs on the falling edge and advances its arithmetic model once per rising edge. It compares both outputs at the next falling edge, so every check looks at the result of exactly one edge. Multi-edge scenarios, such as the five-edge leak and the 32-edge firing run, are checked edge by edge rather than only at the end.

// File: rtl/lif_pkg.sv
// Package: shared types and the default data width of the neuron.
// Assumes unsigned membrane arithmetic throughout.
package lif_pkg;
    localparam int unsigned LIF_DEFAULT_W = 8;

    // Phase of the membrane update selected by the phase control input
    typedef enum logic {
        PH_INTEGRATE = 1'b0,
        PH_LEAK      = 1'b1
    } lif_phase_e;
endpackage

// File: rtl/lif_operand_sel.sv
// Operand selector: chooses the second adder operand and the carry-in.
// Integrate: operand = synaptic input, carry 0.
// Leak: operand = ~leak, carry 1 (two's complement subtraction).
module lif_operand_sel
    import lif_pkg::*;
#(
    parameter int unsigned W = LIF_DEFAULT_W
) (
    input  lif_phase_e     phase,
    input  logic [W-1:0]   syn_val,
    input  logic [W-1:0]   leak_val,
    output logic [W-1:0]   operand,
    output logic           carry_in
);
    // Pick operand and carry from the phase
    always_comb begin
        if (phase == PH_LEAK) begin
            operand  = ~leak_val;
            carry_in = 1'b1;
        end else begin
            operand  = syn_val;
            carry_in = 1'b0;
        end
    end
endmodule

// File: rtl/lif_sat_adder.sv
// Saturating adder: adds the stored potential, the selected operand and the carry.
// The carry-out means overflow in the integrate phase (result pinned to all ones).
// In the leak phase, a missing carry-out means a borrow (result pinned to zero).
module lif_sat_adder
    import lif_pkg::*;
#(
    parameter int unsigned W = LIF_DEFAULT_W
) (
    input  lif_phase_e     phase,
    input  logic [W-1:0]   acc,
    input  logic [W-1:0]   operand,
    input  logic           carry_in,
    output logic [W-1:0]   result
);
    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

    logic [W:0] raw_sum;
    logic       carry_out;

    // Full-width sum with an extra bit for the carry-out
    always_comb begin
        raw_sum   = {1'b0, acc} + {1'b0, operand} + {{W{1'b0}}, carry_in};
        carry_out = raw_sum[W];
    end

    // Apply saturation or the zero clamp depending on the phase
    always_comb begin
        if (phase == PH_LEAK) begin
            result = carry_out ? raw_sum[W-1:0] : '0;
        end else begin
            result = carry_out ? ALL_ONES : raw_sum[W-1:0];
        end
    end

    // R3/R5: the output never falls below the potential when integrating,
    // and never rises above it when leaking
    always_comb begin
        if (!$isunknown({phase, acc, operand, carry_in})) begin
            if (phase == PH_INTEGRATE)
                a_no_wrap_int_r3: assert (result >= acc);
            else
                a_no_wrap_leak_r5: assert (result <= acc);
        end
    end
endmodule

// File: rtl/lif_msb_cmp.sv
// MSB-first magnitude comparator: ge = (val >= level).
// A chain runs from the top bit down. The first unequal bit decides;
// lower bits only matter while all higher bits are equal.
module lif_msb_cmp #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] val,
    input  logic [W-1:0] level,
    output logic         ge
);
    logic [W:0] gt_chain;
    logic [W:0] eq_chain;

    assign gt_chain[W] = 1'b0;
    assign eq_chain[W] = 1'b1;

    // One stage per bit, most significant first
    for (genvar i = W - 1; i >= 0; i--) begin : g_stage
        assign gt_chain[i] = gt_chain[i+1] | (eq_chain[i+1] & val[i] & ~level[i]);
        assign eq_chain[i] = eq_chain[i+1] & ~(val[i] ^ level[i]);
    end

    assign ge = gt_chain[0] | eq_chain[0];

    // R8: the bit chain agrees with an arithmetic comparison
    always_comb begin
        if (!$isunknown({val, level}))
            a_cmp_agrees_r8: assert (ge == (val >= level));
    end
endmodule

// File: rtl/lif_neuron_core.sv
// Leaky integrate-and-fire neuron, top level.
// Holds the potential and spike registers. A fire forces zero into the
// potential through the feedback multiplexer. Reset is synchronous, active low.
// Assumes fire_level is stable or changes only between edges (any value is legal).
module lif_neuron_core
    import lif_pkg::*;
#(
    parameter int unsigned W = LIF_DEFAULT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] syn_in,
    input  logic         leak_phase,
    input  logic [W-1:0] leak_amt,
    input  logic [W-1:0] fire_level,
    output logic         spike,
    output logic [W-1:0] potential
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};

    lif_phase_e   phase;
    logic [W-1:0] operand;
    logic         carry_in;
    logic [W-1:0] next_val;
    logic         fire_now;
    logic [W-1:0] pot_q;
    logic         spike_q;

    assign phase = leak_phase ? PH_LEAK : PH_INTEGRATE;

    lif_operand_sel #(.W(W)) u_opsel (
        .phase    (phase),
        .syn_val  (syn_in),
        .leak_val (leak_amt),
        .operand  (operand),
        .carry_in (carry_in)
    );

    lif_sat_adder #(.W(W)) u_adder (
        .phase    (phase),
        .acc      (pot_q),
        .operand  (operand),
        .carry_in (carry_in),
        .result   (next_val)
    );

    lif_msb_cmp #(.W(W)) u_cmp (
        .val   (next_val),
        .level (fire_level),
        .ge    (fire_now)
    );

    // Potential register behind the reset multiplexer; spike register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pot_q   <= '0;
            spike_q <= 1'b0;
        end else begin
            pot_q   <= fire_now ? '0 : next_val;
            spike_q <= fire_now;
        end
    end

    assign potential = pot_q;
    assign spike     = spike_q;

    // Reference integrate step used only by the assertions
    function automatic logic [W-1:0] ref_int(input logic [W-1:0] p, input logic [W-1:0] d);
        int unsigned s;
        s = int'(p) + int'(d);
        return (s > int'(MAXV)) ? MAXV : W'(s);
    endfunction

    // Reference leak step used only by the assertions
    function automatic logic [W-1:0] ref_leak(input logic [W-1:0] p, input logic [W-1:0] d);
        return (p >= d) ? (p - d) : '0;
    endfunction

    p_reset_clears_r1: assert property (@(posedge clk)
        !rst_n |=> (potential == '0 && !spike));

    p_int_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !leak_phase |=> (spike || potential == ref_int($past(potential), $past(syn_in))));

    p_leak_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        leak_phase |=> (spike || potential == ref_leak($past(potential), $past(leak_amt))));

    p_fire_follows_cmp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fire_now |=> spike);

    p_no_fire_no_spike_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !fire_now |=> !spike);

    p_spike_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        spike |-> potential == '0);

    p_zero_level_fires_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_level == '0) |=> spike);
endmodule

// File: tb/test_lif_neuron_core.sv
// Bench: an arithmetic model advanced once per rising edge; outputs compared
// on the falling edge. Sweeps cover the integrate, leak and threshold spaces.
module test_lif_neuron_core;
    localparam int CLK_PERIOD = 10;
    localparam int MAXV = 255;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] syn_in = '0;
    logic       leak_phase = 1'b0;
    logic [7:0] leak_amt = '0;
    logic [7:0] fire_level = 8'hFF;
    logic       spike;
    logic [7:0] potential;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    int m_pot = 0;
    bit m_spike = 1'b0;

    lif_neuron_core i_lif_neuron_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .syn_in     (syn_in),
        .leak_phase (leak_phase),
        .leak_amt   (leak_amt),
        .fire_level (fire_level),
        .spike      (spike),
        .potential  (potential)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Watchdog: a hung run counts as a failure and still prints the summary
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles, expected fewer than 150000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // One edge: inputs applied, model advanced, outputs sampled on the falling edge
    task automatic step(input bit rst, input int inval, input bit lk, input int lkv, input int thr);
        int nxt;
        rst_n      = ~rst;
        syn_in     = 8'(inval);
        leak_phase = lk;
        leak_amt   = 8'(lkv);
        fire_level = 8'(thr);
        @(posedge clk);
        if (rst) begin
            m_pot = 0;
            m_spike = 1'b0;
        end else begin
            if (lk) nxt = (m_pot >= lkv) ? m_pot - lkv : 0;
            else    nxt = (m_pot + inval > MAXV) ? MAXV : m_pot + inval;
            m_spike = (nxt >= thr);
            m_pot   = m_spike ? 0 : nxt;
        end
        @(negedge clk);
    endtask

    task automatic check(input string tag);
        checks++;
        if (potential !== 8'(m_pot) || spike !== m_spike) begin
            errors++;
            $display("FAIL %s: actual potential=%0d spike=%0b, expected potential=%0d spike=%0b",
                     tag, potential, spike, m_pot, m_spike);
        end
    endtask

    initial begin
        @(negedge clk);
        step(1, 0, 0, 0, 255);
        step(1, 0, 0, 0, 255);
        check("R1 reset state");

        // R6/R7: input 1, level 32, fires on the 32nd edge and restarts
        for (int k = 1; k <= 34; k++) begin
            step(0, 1, 0, 0, 32);
            check((k == 32) ? "R6 fire at 32nd edge" : "R7 integrate then restart");
        end

        // R4: reach 11, leak 1 for five edges, ends at 6
        step(1, 0, 0, 0, 255);
        step(0, 11, 0, 0, 255);
        check("R2 load 11");
        for (int k = 0; k < 5; k++) begin
            step(0, 0, 1, 1, 255);
            check("R4 leak by one per edge");
        end
        checks++;
        if (potential !== 8'd6) begin
            errors++;
            $display("FAIL R4 five-edge leak: actual %0d, expected 6", potential);
        end

        // R2/R3/R4/R5: integrate and leak sweep from many start values
        for (int a = 0; a < 256; a += 5) begin
            for (int b = 0; b < 256; b += 7) begin
                step(1, 0, 0, 0, 255);
                step(0, a, 0, 0, 255);
                check("R2 first add");
                step(0, b, 0, 0, 255);
                check((a + b > MAXV) ? "R3 saturate and fire" : "R2 integrate");
                step(0, 0, 1, b + 3, 255);
                check((m_pot == 0) ? "R5 leak clamp at zero" : "R4 leak subtract");
            end
        end

        // R8: every firing level against a spread of potentials
        for (int t = 0; t < 256; t++) begin
            for (int v = 0; v < 255; v += 11) begin
                step(1, 0, 0, 0, 255);
                step(0, v, 0, 0, 255);
                step(0, 0, 0, 0, t);
                check("R8 compare level");
            end
        end

        // R9: level zero fires on every edge and keeps the potential at zero
        step(1, 0, 0, 0, 255);
        for (int k = 0; k < 4; k++) begin
            step(0, 9, 0, 0, 0);
            check("R9 zero level fires every edge");
        end

        // R1: reset in the middle of integration
        step(0, 40, 0, 0, 255);
        step(0, 40, 0, 0, 255);
        step(1, 40, 0, 0, 255);
        check("R1 mid-run reset");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule